// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port for clocked shift transfers in which the port itself supplies the shift clock. A free-running slot counter divides the oscillator clock into machine cycles of twelve slots. The slots are named S1P1 through S6P2, one state of two phases for each pair. Each transfer moves one byte at one bit per machine cycle, least significant bit first. Outgoing bits go on the data line. The shift clock is driven on a separate pin.

A transmit begins when a byte is handed over on a valid/ready port. The port raises `tx_ready` only in slot S6P2, and only when no transfer is pending or running in either direction. A source with `tx_valid` high is held off until that slot comes. The byte is not taken before then, and `tx_data` must stay stable while `tx_valid` is high. A receive begins when `rx_en` is high and the receive-done flag is clear. When it finishes, the assembled byte appears on `rx_data`. Both done flags stay set until software pulses their clear inputs.

The data line is split into pad-level pins: `sd_out` carries the output level, `sd_oe` is the drive enable and `sd_in` is the input. The shift registers carry a marker bit, and the marker ends each transfer, so no separate bit counter is used.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk_out`=1, `sd_oe`=0, `tx_done`=0, `rx_done`=0 and `rx_data`=0.
- R2: A machine cycle is 12 clocks. `tx_ready` is high only in the last slot (S6P2), and only when both directions are idle. A byte is accepted on the rising edge where `tx_valid` and `tx_ready` are both high. Call the machine cycle that ends at this edge cycle 0.
- R3: While transmitting, `sd_oe` is 1 throughout cycles 2 to 9 after the write, and 0 in cycle 1 and from cycle 10 onward.
- R4: In cycle 2+k (k = 0..7), `sd_out` carries bit k of the written byte.
- R5: During a transfer in either direction, `sclk_out` is 0 in slots 4 to 9 (S3P1 to S5P2) and 1 in slots 0 to 3 and 10 to 11. It is 1 whenever the port is idle.
- R6: `tx_done` sets at the start of cycle 10 after the write and holds until `tx_done_clr` is pulsed. If a clear arrives on the same edge as the set, the set wins.
- R7: A receive is armed on the S6P2 edge of any cycle in which `rx_en`=1, `rx_done`=0, the port is idle and no byte is being accepted. That cycle is cycle 0. The receive is active in cycles 2 to 9, with `sd_oe` kept at 0.
- R8: The level of `sd_in` at the end of slot 9 (S5P2) of cycle 2+k becomes bit k of `rx_data`. Levels in any other slot have no effect.
- R9: `rx_data` updates and `rx_done` sets at the start of cycle 10. `rx_done` holds until `rx_done_clr` is pulsed, and a set wins over a coincident clear.
- R10: While `rx_done`=1, holding `rx_en`=1 starts nothing: `sclk_out` stays 1.
- R11: The two directions never run together. `tx_ready` stays 0 from the arming of a receive until it completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Byte offered for transmit |
| tx_ready | output | 1 | Port accepts the byte this cycle |
| tx_data | input | DATA_W | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| rx_data | output | DATA_W | Last received byte |
| tx_done | output | 1 | Transmit-done flag |
| tx_done_clr | input | 1 | Clears `tx_done` |
| rx_done | output | 1 | Receive-done flag |
| rx_done_clr | input | 1 | Clears `rx_done` |
| sd_in | input | 1 | Data line input level |
| sd_out | output | 1 | Data line output level |
| sd_oe | output | 1 | Data line drive enable |
| sclk_out | output | 1 | Shift clock |

## Verification
A done flag can be set by the end of a transfer and cleared by software on the same clock edge. The bench provokes this in every fourth transfer by pulsing the clear input in the S6P2 slot of cycle 9, which is exactly the edge that sets the flag. It then expects the flag to read 1 in the next slot. A separate clear pulse afterwards must bring the flag to 0, which shows that the clear path itself works. All 256 byte values are sent and received. On receive, the bench drives the inverted bit in every slot except S5P2, so a sample taken in any other slot is caught.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned CYC_SLOTS   = 12; // two phases for each of six states
  localparam int unsigned SLOT_SAMPLE = 9;  // S5P2
  localparam int unsigned SLOT_LOW_LO = 4;  // S3P1
  localparam int unsigned SLOT_LOW_HI = 9;  // S5P2
  localparam int unsigned BYTE_W      = 8;
endpackage

// File: rtl/ssp_timing.sv
module ssp_timing #(
  parameter int unsigned SLOTS  = ssp_pkg::CYC_SLOTS,
  parameter int unsigned SAMPLE = ssp_pkg::SLOT_SAMPLE,
  parameter int unsigned LOW_LO = ssp_pkg::SLOT_LOW_LO,
  parameter int unsigned LOW_HI = ssp_pkg::SLOT_LOW_HI
) (
  input  logic clk,
  input  logic rst_n,
  output logic end_o,
  output logic samp_o,
  output logic low_o
);
  localparam int unsigned SW = $clog2(SLOTS);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign end_o  = (slot_q == LAST);
  assign samp_o = (slot_q == SW'(SAMPLE));
  assign low_o  = (slot_q >= SW'(LOW_LO)) && (slot_q <= SW'(LOW_HI));
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int unsigned DATA_W = ssp_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  output logic              active_o,
  output logic              busy_o,
  output logic              bit_o,
  output logic              done_o
);
  logic [DATA_W:0] sh_q;
  logic            armed_q, send_q, done_q;
  logic            last_shift;

  // marker sits just above the MSB and nothing above it
  assign last_shift = (sh_q[DATA_W:2] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      armed_q <= 1'b0;
      send_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        sh_q    <= {1'b1, wr_data_i};
        armed_q <= 1'b1;
      end else if (end_i && armed_q) begin
        armed_q <= 1'b0;
        send_q  <= 1'b1;
      end else if (end_i && send_q) begin
        sh_q <= {1'b0, sh_q[DATA_W:1]};
        if (last_shift) send_q <= 1'b0;
      end
      if (end_i && send_q && last_shift) done_q <= 1'b1;
      else if (clr_i)                    done_q <= 1'b0;
    end
  end

  assign active_o = send_q;
  assign busy_o   = armed_q | send_q;
  assign bit_o    = sh_q[0];
  assign done_o   = done_q;

  AST_TX_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(send_q) |-> done_q); // R6
  AST_TX_SEND_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_q) |-> $past(armed_q)); // R3
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int unsigned DATA_W = ssp_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_i,
  input  logic              samp_i,
  input  logic              start_ok_i,
  input  logic              din_i,
  input  logic              clr_i,
  output logic              active_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic [DATA_W-1:0] sh_q, sh_next, rev;
  logic [DATA_W-1:0] data_q;
  logic              armed_q, recv_q, done_q, samp_q;
  logic              last_shift;

  assign sh_next    = {sh_q[DATA_W-2:0], samp_q};
  assign last_shift = ~sh_q[DATA_W-1];

  // first bit in ends up leftmost; flip so it lands in bit 0
  always_comb begin
    for (int i = 0; i < DATA_W; i++) rev[i] = sh_next[DATA_W-1-i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      armed_q <= 1'b0;
      recv_q  <= 1'b0;
      done_q  <= 1'b0;
      samp_q  <= 1'b0;
    end else begin
      if (samp_i) samp_q <= din_i;
      if (end_i && armed_q) begin
        armed_q <= 1'b0;
        recv_q  <= 1'b1;
        sh_q    <= {{(DATA_W-1){1'b1}}, 1'b0};
      end else if (end_i && recv_q) begin
        sh_q <= sh_next;
        if (last_shift) begin
          recv_q <= 1'b0;
          data_q <= rev;
        end
      end else if (end_i && start_ok_i && !done_q) begin
        armed_q <= 1'b1;
      end
      if (end_i && recv_q && last_shift) done_q <= 1'b1;
      else if (clr_i)                    done_q <= 1'b0;
    end
  end

  assign active_o = recv_q;
  assign busy_o   = armed_q | recv_q;
  assign data_o   = data_q;
  assign done_o   = done_q;

  AST_RX_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recv_q) |-> done_q); // R9
  AST_RX_NO_ARM_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> !$past(done_q)); // R10
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int unsigned DATA_W = ssp_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_done,
  input  logic              tx_done_clr,
  output logic              rx_done,
  input  logic              rx_done_clr,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic              sclk_out
);
  logic slot_end, slot_samp, slot_low;
  logic tx_act, tx_busy, tx_bit;
  logic rx_act, rx_busy;
  logic wr_fire, rx_start_ok;

  ssp_timing u_timing (
    .clk    (clk),
    .rst_n  (rst_n),
    .end_o  (slot_end),
    .samp_o (slot_samp),
    .low_o  (slot_low)
  );

  assign tx_ready    = slot_end && !tx_busy && !rx_busy;
  assign wr_fire     = tx_valid && tx_ready;
  // a byte accepted on the same edge takes precedence over arming a receive
  assign rx_start_ok = rx_en && !tx_busy && !wr_fire;

  ssp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_i     (slot_end),
    .wr_i      (wr_fire),
    .wr_data_i (tx_data),
    .clr_i     (tx_done_clr),
    .active_o  (tx_act),
    .busy_o    (tx_busy),
    .bit_o     (tx_bit),
    .done_o    (tx_done)
  );

  ssp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .end_i      (slot_end),
    .samp_i     (slot_samp),
    .start_ok_i (rx_start_ok),
    .din_i      (sd_in),
    .clr_i      (rx_done_clr),
    .active_o   (rx_act),
    .busy_o     (rx_busy),
    .data_o     (rx_data),
    .done_o     (rx_done)
  );

  assign sd_out   = tx_bit;
  assign sd_oe    = tx_act;
  assign sclk_out = (tx_act || rx_act) ? !slot_low : 1'b1;

  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_busy)); // R11
endmodule

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_en = 1'b0;
  logic [7:0] rx_data;
  logic       tx_done, rx_done;
  logic       tx_done_clr = 1'b0;
  logic       rx_done_clr = 1'b0;
  logic       sd_in = 1'b0;
  logic       sd_out, sd_oe, sclk_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sync_shift_port i_sync_shift_port (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_en(rx_en), .rx_data(rx_data), .tx_done(tx_done),
    .tx_done_clr(tx_done_clr), .rx_done(rx_done), .rx_done_clr(rx_done_clr),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe), .sclk_out(sclk_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_sclk(input int cyc, input int sl);
    if (cyc < 2 || cyc > 9) return 1'b1;
    return !(sl >= 4 && sl <= 9);
  endfunction

  task automatic do_tx(input logic [7:0] b, input bit collide);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    #1 tx_valid = 1'b0;
    for (int k = 0; k < 108; k++) begin
      int cyc, sl;
      bit act;
      @(negedge clk);
      cyc = 1 + k / 12;
      sl  = k % 12;
      act = (cyc >= 2);
      chk(sd_oe == act, "R3 drive enable", sd_oe, act);
      if (act) chk(sd_out == b[cyc-2], "R4 data bit", sd_out, b[cyc-2]);
      chk(sclk_out == exp_sclk(cyc, sl), "R5 tx shift clock", sclk_out, exp_sclk(cyc, sl));
      chk(tx_done == 1'b0, "R6 early done", tx_done, 0);
      chk(tx_ready == 1'b0, "R2 ready while busy", tx_ready, 0);
      if (collide && k == 107) tx_done_clr = 1'b1;
    end
    @(negedge clk);
    tx_done_clr = 1'b0;
    chk(tx_done == 1'b1, "R6 done set", tx_done, 1);
    chk(sd_oe == 1'b0, "R3 released", sd_oe, 0);
    chk(sclk_out == 1'b1, "R5 idle clock", sclk_out, 1);
    @(negedge clk);
    chk(tx_done == 1'b1, "R6 done holds", tx_done, 1);
    tx_done_clr = 1'b1;
    @(negedge clk);
    tx_done_clr = 1'b0;
    chk(tx_done == 1'b0, "R6 clear", tx_done, 0);
  endtask

  task automatic do_rx(input logic [7:0] b, input bit collide);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    rx_en = 1'b1;
    for (int k = 0; k < 108; k++) begin
      int cyc, sl;
      @(negedge clk);
      cyc = 1 + k / 12;
      sl  = k % 12;
      if (cyc >= 2) sd_in = (sl == 9) ? b[cyc-2] : ~b[cyc-2];
      else          sd_in = 1'b0;
      chk(sclk_out == exp_sclk(cyc, sl), "R7 rx shift clock", sclk_out, exp_sclk(cyc, sl));
      chk(sd_oe == 1'b0, "R7 line released", sd_oe, 0);
      chk(rx_done == 1'b0, "R9 early done", rx_done, 0);
      chk(tx_ready == 1'b0, "R11 ready during receive", tx_ready, 0);
      if (collide && k == 107) rx_done_clr = 1'b1;
    end
    @(negedge clk);
    rx_done_clr = 1'b0;
    chk(rx_done == 1'b1, "R9 done set", rx_done, 1);
    chk(rx_data == b, "R8 received byte", rx_data, b);
    for (int j = 0; j < 36; j++) begin
      @(negedge clk);
      chk(sclk_out == 1'b1, "R10 no restart while done", sclk_out, 1);
    end
    chk(rx_done == 1'b1, "R9 done holds", rx_done, 1);
    rx_en = 1'b0;
    rx_done_clr = 1'b1;
    @(negedge clk);
    rx_done_clr = 1'b0;
    chk(rx_done == 1'b0, "R9 clear", rx_done, 0);
    chk(rx_data == b, "R9 data held", rx_data, b);
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_out == 1'b1, "R1 reset clock", sclk_out, 1);
    chk(sd_oe == 1'b0, "R1 reset enable", sd_oe, 0);
    chk(tx_done == 1'b0, "R1 reset tx flag", tx_done, 0);
    chk(rx_done == 1'b0, "R1 reset rx flag", rx_done, 0);
    chk(rx_data == 8'h00, "R1 reset data", rx_data, 0);
    rst_n = 1'b1;
    // R2: tx_ready appears exactly once per 12 clocks while idle
    begin
      int first, gap;
      first = -1;
      gap = 0;
      for (int n = 0; n < 30; n++) begin
        @(negedge clk);
        if (tx_ready) begin
          if (first >= 0) gap = n - first;
          first = n;
        end
      end
      chk(gap == 12, "R2 cycle length", gap, 12);
    end
    for (int v = 0; v < 256; v++) do_tx(8'(v), (v % 4) == 3);
    for (int v = 0; v < 256; v++) do_rx(8'(v ^ 8'h5a), (v % 4) == 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule